// File: doc/BRIEF.md
# Two-Bit-Per-Clock Augmented CRC-8 Engine

This block computes an 8-bit cyclic redundancy check over a serial message with the generator x^8 + x^4 + x^3 + x^2 + 1. The message is fed most significant bit first. Each clock absorbs one 2-bit beat into an 8-bit remainder register. The register holds the coefficients of x^7 down to x^0 over GF(2). Each clock shifts the remainder up by two powers. Any coefficient pushed to x^8 or x^9 is folded back down: x^8 becomes x^4+x^3+x^2+1 (0x1D) and x^9 becomes x^5+x^4+x^3+x (0x3A).

A user pulses `crc_clr` to start a message, presents beats with `beat_vld`, and flags the final beat with `beat_last`. The engine then appends the eight zero bits of the augmented form by itself, over four internal cycles. It then pulses `crc_done`. The result is the message polynomial times x^8, reduced modulo the generator. It starts from zero with no final inversion, and it stays on `crc_out` until the next clear. Messages must hold an even number of bits.

Top module: `crc8_aug_dual`

## Requirements
- R1: After `rst`, `crc_out` is 0x00 and `crc_done` is 0.
- R2: `crc_clr` high at a clock edge makes `crc_out` 0x00 from the next cycle and starts a new message, abandoning any message or flush in progress.
- R3: A beat accepted while a message is open updates the remainder to (remainder·x^2 + b1·x + b0) mod generator. `beat_bits[1]` is b1, the earlier bit, and `beat_bits[0]` is b0.
- R4: While a message is open, a cycle with `beat_vld` low leaves `crc_out` unchanged.
- R5: After the beat flagged by `beat_last` is accepted, four zero-input folds follow. `crc_done` is high in the fifth cycle after the cycle that presented the last beat, and low in the four cycles between.
- R6: The final `crc_out` equals message·x^8 mod (x^8+x^4+x^3+x^2+1), with a zero start value and no final XOR. The 16-bit message 0x0001 gives 0x1D.
- R7: During the flush and after done, `beat_vld`, `beat_bits` and `beat_last` have no effect. `crc_out` holds the result until the next `crc_clr`.
- R8: `crc_done` is high for exactly one cycle per message.
- R9: An all-zero message of any even length gives 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_clr | input | 1 | Synchronous clear and message start |
| beat_vld | input | 1 | Qualifies `beat_bits` this cycle |
| beat_bits | input | 2 | Two message bits; bit 1 is earlier in the message |
| beat_last | input | 1 | Marks the final beat of the message |
| crc_out | output | 8 | Remainder register; the CRC once done |
| crc_done | output | 1 | One-cycle pulse when the CRC is final |

## Verification
A fixed table of single-term messages (x^0, x^1, x^7 and x^8 shifted through the augmentation) is used. Each expected result is a hand-reduced power of x, so a wrong fold constant for either the x^8 or the x^9 overflow shows up on its own. All-zero messages and a 2-bit message test the zero start value and the case of a single beat that is also the last beat. Random messages of random even length, with idle gaps, are compared against a bit-serial long-division model. These runs tell apart errors in bit order within a beat, in the idle hold and in the flush count. Directed cases also drive junk beats during the flush, a clear in the middle of a message and a partial remainder after two beats.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W  = 8;
  localparam int BEAT_W = 2;
  localparam logic [CRC_W-1:0] GEN_LOW = 8'h1D;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FLUSH = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;
endpackage

// File: rtl/crc_fold2.sv
module crc_fold2 #(
  parameter int          W    = crc8_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc8_pkg::GEN_LOW
) (
  input  logic [W-1:0] rem_in,
  input  logic [1:0]   bits_in,
  output logic [W-1:0] rem_nxt
);
  // Reduced forms of the two overflow powers.
  localparam logic [W-1:0] RED_XW  = POLY;
  localparam logic [W-1:0] RED_XW1 = {POLY[W-2:0], 1'b0} ^ (POLY[W-1] ? POLY : '0);

  logic [W-1:0] shifted;

  always_comb begin
    shifted = {rem_in[W-3:0], bits_in};
    rem_nxt = shifted
            ^ ({W{rem_in[W-2]}} & RED_XW)
            ^ ({W{rem_in[W-1]}} & RED_XW1);
  end

  // An all-zero remainder and zero input must stay zero.
  always_comb begin
    if (rem_in == '0 && bits_in == 2'b00)
      a_zero_fixed_r9: assert (rem_nxt == '0);
  end
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl #(
  parameter int FLUSH_BEATS = crc8_pkg::CRC_W / crc8_pkg::BEAT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            vld,
  input  logic            last,
  output logic            fold_en,
  output logic            zero_in,
  output logic            done,
  output crc8_pkg::phase_t phase
);
  import crc8_pkg::*;

  localparam int CNT_W = (FLUSH_BEATS > 1) ? $clog2(FLUSH_BEATS) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FLUSH_BEATS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        phase <= PH_RUN;
        cnt   <= '0;
      end else begin
        case (phase)
          PH_RUN: begin
            if (vld && last) begin
              phase <= PH_FLUSH;
              cnt   <= '0;
            end
          end
          PH_FLUSH: begin
            if (cnt == CNT_END) begin
              phase <= PH_HOLD;
              done  <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    zero_in = (phase == PH_FLUSH);
    fold_en = !clr && ((phase == PH_RUN && vld) || phase == PH_FLUSH);
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_flush_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(phase) == PH_FLUSH && phase == PH_HOLD));

  p_clr_restarts_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase == PH_RUN && !done));
endmodule

// File: rtl/crc8_aug_dual.sv
module crc8_aug_dual #(
  parameter int            CRC_W = crc8_pkg::CRC_W,
  parameter logic [CRC_W-1:0] POLY = crc8_pkg::GEN_LOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             crc_clr,
  input  logic             beat_vld,
  input  logic [1:0]       beat_bits,
  input  logic             beat_last,
  output logic [CRC_W-1:0] crc_out,
  output logic             crc_done
);
  import crc8_pkg::*;

  localparam int FLUSH_BEATS = CRC_W / 2;

  logic             fold_en;
  logic             zero_in;
  phase_t           phase;
  logic [1:0]       fold_bits;
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_d;

  crc_ctrl #(.FLUSH_BEATS(FLUSH_BEATS)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clr     (crc_clr),
    .vld     (beat_vld),
    .last    (beat_last),
    .fold_en (fold_en),
    .zero_in (zero_in),
    .done    (crc_done),
    .phase   (phase)
  );

  assign fold_bits = zero_in ? 2'b00 : beat_bits;

  crc_fold2 #(.W(CRC_W), .POLY(POLY)) u_fold (
    .rem_in  (rem_q),
    .bits_in (fold_bits),
    .rem_nxt (rem_d)
  );

  always_ff @(posedge clk) begin
    if (rst || crc_clr)
      rem_q <= '0;
    else if (fold_en)
      rem_q <= rem_d;
  end

  assign crc_out = rem_q;

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (rst)
    crc_clr |=> (crc_out == '0));

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && !beat_vld && !crc_clr) |=> $stable(crc_out));

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && !crc_clr) |=> $stable(crc_out));

  p_flush_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLUSH && !crc_clr) |=> (crc_out == $past(rem_d)));
endmodule

// File: tb/test_crc8_aug_dual.sv
module test_crc8_aug_dual;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // Table: message (right-aligned), bit length, expected CRC.
  localparam logic [63:0] T_MSG [NVEC] = '{64'h0001, 64'h0000, 64'h02, 64'h80, 64'h0100, 64'h3};
  localparam int          T_LEN [NVEC] = '{16, 16, 8, 8, 16, 2};
  localparam logic [7:0]  T_EXP [NVEC] = '{8'h1D, 8'h00, 8'h3A, 8'h26, 8'h4C, 8'h27};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crc_clr = 1'b0;
  logic       beat_vld = 1'b0;
  logic [1:0] beat_bits = 2'b00;
  logic       beat_last = 1'b0;
  logic [7:0] crc_out;
  logic       crc_done;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc8_aug_dual i_crc8_aug_dual (
    .clk       (clk),
    .rst       (rst),
    .crc_clr   (crc_clr),
    .beat_vld  (beat_vld),
    .beat_bits (beat_bits),
    .beat_last (beat_last),
    .crc_out   (crc_out),
    .crc_done  (crc_done)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // Bit-serial long division of msg followed by eight zeros.
  function automatic logic [7:0] ref_crc(input logic [63:0] msg, input int len);
    logic [7:0] r = 8'h00;
    for (int i = len + 7; i >= 0; i--) begin
      logic b = (i >= 8) ? msg[i-8] : 1'b0;
      logic top = r[7];
      r = {r[6:0], b};
      if (top) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  // Runs one full message and checks timing, result and hold.
  task automatic run_msg(input logic [63:0] msg, input int len, input logic [7:0] exp,
                         input bit gaps, input bit junk, input string req);
    int nb = len / 2;
    logic [7:0] held;
    @(negedge clk); crc_clr = 1'b1;
    @(negedge clk); crc_clr = 1'b0;
    for (int i = 0; i < nb; i++) begin
      if (gaps && ($urandom_range(0, 3) == 0)) begin
        beat_vld = 1'b0;
        @(negedge clk);
      end
      beat_vld  = 1'b1;
      beat_bits = 2'((msg >> (len - 2 - 2*i)) & 64'h3);
      beat_last = (i == nb - 1);
      @(negedge clk);
    end
    beat_vld  = junk;
    beat_bits = junk ? 2'b11 : 2'b00;
    beat_last = junk;
    // R5: done low for four cycles, high in the fifth
    for (int k = 0; k < 5; k++) begin
      chk(crc_done == (k == 4), "R5 done timing", {7'd0, crc_done}, {7'd0, k == 4});
      if (k < 4) @(negedge clk);
    end
    chk(crc_out == exp, req, crc_out, exp);
    held = crc_out;
    @(negedge clk);
    chk(crc_done == 1'b0, "R8 done single pulse", {7'd0, crc_done}, 8'h00);
    @(negedge clk);
    chk(crc_out == held, "R7 result held", crc_out, held);
    beat_vld = 1'b0; beat_bits = 2'b00; beat_last = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(crc_out == 8'h00, "R1 reset crc", crc_out, 8'h00);
    chk(crc_done == 1'b0, "R1 reset done", {7'd0, crc_done}, 8'h00);

    // Table walk (R6, R9 for the zero row)
    for (int v = 0; v < NVEC; v++) begin
      chk(ref_crc(T_MSG[v], T_LEN[v]) == T_EXP[v], "R6 model vs table",
          ref_crc(T_MSG[v], T_LEN[v]), T_EXP[v]);
      run_msg(T_MSG[v], T_LEN[v], T_EXP[v], 1'b0, 1'b0, "R6 table crc");
    end

    // R9: long all-zero message with gaps
    run_msg(64'h0, 64, 8'h00, 1'b1, 1'b0, "R9 zero message");

    // R7: junk beats during flush are ignored
    run_msg(64'h0001, 16, 8'h1D, 1'b0, 1'b1, "R7 junk during flush");

    // R3 partial remainder, R4 idle hold, R2 mid-message clear
    @(negedge clk); crc_clr = 1'b1;
    @(negedge clk); crc_clr = 1'b0; beat_vld = 1'b1; beat_bits = 2'b11;
    @(negedge clk); beat_vld = 1'b0;
    chk(crc_out == 8'h03, "R3 first beat", crc_out, 8'h03);
    repeat (3) @(negedge clk);
    chk(crc_out == 8'h03, "R4 idle hold", crc_out, 8'h03);
    beat_vld = 1'b1; beat_bits = 2'b01;
    @(negedge clk); beat_vld = 1'b0;
    chk(crc_out == 8'h0D, "R3 second beat bit order", crc_out, 8'h0D);
    crc_clr = 1'b1;
    @(negedge clk); crc_clr = 1'b0;
    chk(crc_out == 8'h00, "R2 clear mid message", crc_out, 8'h00);
    run_msg(64'h80, 8, 8'h26, 1'b0, 1'b0, "R2 restart after clear");

    // R6: random even-length messages against the long-division model
    for (int t = 0; t < 40; t++) begin
      int len = 2 * (1 + int'($urandom_range(0, 31)));
      logic [63:0] msg = {$urandom, $urandom};
      if (len < 64) msg = msg & ((64'd1 << len) - 64'd1);
      run_msg(msg, len, ref_crc(msg, len), 1'b1, t[0], "R6 random crc");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule